// File: doc/BRIEF.md
# Serial Management Frame Engine

This block is the master side of a two-wire PHY management link. Software writes one 32-bit command word into the data register. The upper bits of that word already hold the start pattern, the opcode, the PHY address, the register number and the turnaround pattern, and the lower half holds write data. The engine sends a run of preamble ones and then the 32 command bits, most significant bit first, on the data line, while it toggles the management clock. For a read, the engine lets go of the data line for the turnaround and data phases. It collects the 16 bits the PHY returns and places them in the low half of the data register.

When the frame ends, the engine sets a completion bit in an event register, and software clears that bit by writing a one to it. A command word written while a frame is running is dropped, and a sticky overlap bit records that it happened. The management clock period is twice the programmed divider value, counted in system clocks. The divider is programmed so that the management clock stays at or below 2.5 MHz. A read from an address where no PHY answers returns 0xFFFF, because the data line is pulled high.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: After reset, the data register and the event register read 0, the management clock is low, the data line is released (output enable 0) and the divider reads DIV_INIT (4 by default).
- R2: A command word written while idle starts a frame of PRE_LEN (32) ones followed by command bits 31 down to 0. For a write frame the output enable is high for every bit.
- R3: Each management clock phase lasts `div` system clocks, and a divider of 0 acts as 1. The completion bit is set at the edge exactly 2·(PRE_LEN+32)·div clocks after the edge that accepted the command, which is 128·div clocks at the defaults.
- R4: The data output changes only at a falling edge of the management clock (or when a frame starts). Read data is sampled at the rising edges.
- R5: A command whose bits 29:28 equal 2'b10 is a read. A read releases the data line (output enable 0) for the last 18 frame bits, which carry command bits 17:0.
- R6: When a read completes, bits 15:0 of the data register hold the 16 bits returned (MSB first) and bits 31:16 keep the command. With no PHY driving the line, the result is 0xFFFF.
- R7: When a non-read frame completes, the data register still holds the command word, and the PHY receives bits 15:0 as data.
- R8: Completion sets event bit 23. Writing 1 to bit 23 clears it, and writing 0 leaves it unchanged. A completion in the same cycle as a clear leaves the bit set.
- R9: A command write during a frame is ignored: the running frame and the data register are unaffected. It sets sticky event bit 22, which is cleared by writing 1 to it.
- R10: Between frames the management clock is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the data register |
| cmd_wdata | input | 32 | Command word |
| data_q | output | 32 | Data register contents |
| evt_we | input | 1 | Write strobe for the event register (write-one-to-clear) |
| evt_wdata | input | 32 | Clear mask for the event register |
| evt_q | output | 32 | Event register: bit 23 completion, bit 22 overlap |
| div_we | input | 1 | Write strobe for the divider |
| div_wdata | input | DIV_W | New divider value |
| div_q | output | DIV_W | Current divider value |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The hardest case to reach is a completion that falls in the same system clock cycle as a software clear of the completion bit. The bench can only hit that cycle because the frame length is exactly 128·div clocks. It counts edges from the accepting edge and raises the clear strobe just before the edge on which the frame ends. A second hard case is a command write in the middle of a running read. The bench models a PHY with its own register file, so it can show that the dropped write neither reached the PHY nor disturbed the reply.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;
   localparam int CMD_BITS      = 32;
   localparam int EVT_DONE_POS  = 23;
   localparam int EVT_OVL_POS   = 22;
   localparam int REL_OFFSET    = 14;   // first frame bit released on a read
   localparam int CAP_OFFSET    = 16;   // first frame bit carrying reply data
   localparam logic [1:0] OPC_READ = 2'b10;

   function automatic logic op_is_read(input logic [CMD_BITS-1:0] w);
      return w[29:28] == OPC_READ;
   endfunction
endpackage

// File: rtl/mdc_pacer.sv
module mdc_pacer #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_now,
   output logic             fall_now
);
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt;
   logic             tick;

   assign half     = (div == '0) ? DIV_W'(1) : div;
   assign tick     = run && (cnt >= half - DIV_W'(1));
   assign rise_now = tick && !mdc;
   assign fall_now = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (run) begin
         if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end else begin
         cnt <= '0;
         mdc <= 1'b0;
      end
   end

   // R10: the clock parks low once no frame runs
   p_mdc_parks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
   import mgmt_frame_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CMD_BITS-1:0] cmd,
   input  logic                rise_now,
   input  logic                fall_now,
   input  logic                mdio_i,
   output logic                busy,
   output logic                done,
   output logic                rd,
   output logic                mdio_o,
   output logic                mdio_oe,
   output logic [15:0]         reply
);
   localparam int FRAME_LEN = PRE_LEN + CMD_BITS;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);
   localparam int REL_AT    = PRE_LEN + REL_OFFSET;
   localparam int CAP_AT    = PRE_LEN + CAP_OFFSET;

   logic [IDX_W-1:0]    idx;
   logic [IDX_W-1:0]    nxt;
   logic [CMD_BITS-1:0] cmd_q;

   function automatic logic bit_at(input int k, input logic [CMD_BITS-1:0] w);
      if (k < PRE_LEN) return 1'b1;
      return w[5'(CMD_BITS - 1 - (k - PRE_LEN))];
   endfunction

   assign nxt  = idx + IDX_W'(1);
   assign done = busy && fall_now && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         cmd_q   <= '0;
         rd      <= 1'b0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
         reply   <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         idx     <= '0;
         cmd_q   <= cmd;
         rd      <= op_is_read(cmd);
         mdio_o  <= bit_at(0, cmd);
         mdio_oe <= 1'b1;
         reply   <= '0;
      end else if (busy) begin
         if (rise_now && rd && int'(idx) >= CAP_AT)
            reply <= {reply[14:0], mdio_i};
         if (fall_now) begin
            if (idx == LAST) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b1;
            end else begin
               idx     <= nxt;
               mdio_o  <= bit_at(int'(nxt), cmd_q);
               mdio_oe <= !(rd && int'(nxt) >= REL_AT);
            end
         end
      end
   end

   // R5: on a read the line is released from the turnaround onwards
   p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rd && int'(idx) >= REL_AT |-> !mdio_oe);
   // R2: a write frame drives every bit
   p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !rd |-> mdio_oe);
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
   import mgmt_frame_pkg::*;
#(
   parameter int DIV_W    = 6,
   parameter int DIV_INIT = 4,
   parameter int PRE_LEN  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   output logic [31:0]      data_q,
   input  logic             evt_we,
   input  logic [31:0]      evt_wdata,
   output logic [31:0]      evt_q,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic [DIV_W-1:0] div_q,
   output logic             mdc,
   input  logic             mdio_i,
   output logic             mdio_o,
   output logic             mdio_oe
);
   generate
      if (PRE_LEN < 0 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 0..32");
      end
      if (DIV_W < 1 || DIV_INIT >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_INIT does not fit in DIV_W bits");
      end
   endgenerate

   logic        busy, done, rd;
   logic        rise_now, fall_now;
   logic [15:0] reply;
   logic        accept, overlap;
   logic        evt_done, evt_ovl;

   assign accept  = cmd_we && !busy;
   assign overlap = cmd_we && busy;

   mdc_pacer #(.DIV_W(DIV_W)) pacer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_q),
      .mdc      (mdc),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   frame_shifter #(.PRE_LEN(PRE_LEN)) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .cmd      (cmd_wdata),
      .rise_now (rise_now),
      .fall_now (fall_now),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .done     (done),
      .rd       (rd),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .reply    (reply)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q   <= '0;
         div_q    <= DIV_W'(DIV_INIT);
         evt_done <= 1'b0;
         evt_ovl  <= 1'b0;
      end else begin
         if (accept)
            data_q <= cmd_wdata;
         else if (done && rd)
            data_q[15:0] <= reply;
         if (div_we)
            div_q <= div_wdata;
         evt_done <= done    | (evt_done & ~(evt_we & evt_wdata[EVT_DONE_POS]));
         evt_ovl  <= overlap | (evt_ovl  & ~(evt_we & evt_wdata[EVT_OVL_POS]));
      end
   end

   always_comb begin
      evt_q               = '0;
      evt_q[EVT_DONE_POS] = evt_done;
      evt_q[EVT_OVL_POS]  = evt_ovl;
   end

   // R10: quiet line between frames
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc && !mdio_oe);
   // R4: data only moves with a falling management clock
   p_mdio_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$stable(mdio_o) |-> $fell(mdc));
   // R3: completion only follows a running frame
   p_evt_from_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q[EVT_DONE_POS]) |-> $past(busy));
   // R9: overlapping write is dropped and flagged
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_we |=> $stable(data_q[31:16]) && evt_q[EVT_OVL_POS]);
   // R8: an idle clear removes the completion bit
   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_we && evt_wdata[EVT_DONE_POS] && !busy |=> !evt_q[EVT_DONE_POS]);
endmodule

// File: tb/mgmt_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module mgmt_cmd_engine_tb_top;
   localparam int DIV_W    = 6;
   localparam int PRE      = 32;
   localparam logic [4:0] PHY_ADDR = 5'd5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_we = 1'b0;
   logic [31:0]      cmd_wdata = '0;
   logic [31:0]      data_q;
   logic             evt_we = 1'b0;
   logic [31:0]      evt_wdata = '0;
   logic [31:0]      evt_q;
   logic             div_we = 1'b0;
   logic [DIV_W-1:0] div_wdata = '0;
   logic [DIV_W-1:0] div_q;
   logic             mdc, mdio_o, mdio_oe;
   logic             mdio_w;

   int n_chk = 0;
   int n_fail = 0;

   // PHY model state
   int          rc = 0;
   logic [31:0] sh = '0;
   logic [31:0] last_frame = '0;
   logic        hit = 1'b0;
   logic        drv = 1'b0;
   logic        dbit = 1'b1;
   logic [15:0] rep = '0;
   logic [15:0] phy_regs [32];
   logic        cur_rd = 1'b0;
   int          pre_bad = 0, rel_bad = 0, drv_bad = 0, chg_bad = 0;
   int          exp_half = 4, hi_len = 0, half_bad = 0;
   logic        prev_o = 1'b1, prev_mdc = 1'b0;

   always #2 clk = ~clk;

   assign mdio_w = mdio_oe ? mdio_o : (drv ? dbit : 1'b1);

   mgmt_cmd_engine #(.DIV_W(DIV_W), .DIV_INIT(4), .PRE_LEN(PRE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .data_q(data_q), .evt_we(evt_we), .evt_wdata(evt_wdata), .evt_q(evt_q),
      .div_we(div_we), .div_wdata(div_wdata), .div_q(div_q), .mdc(mdc),
      .mdio_i(mdio_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   always @(posedge mdc) begin
      if (cur_rd && rc - PRE >= 14 && mdio_oe) rel_bad++;
      if ((!cur_rd || rc - PRE < 14) && !mdio_oe) drv_bad++;
      if (rc < PRE && mdio_w !== 1'b1) pre_bad++;
      sh = {sh[30:0], mdio_w};
      rc++;
      if (rc == PRE + 14) begin
         hit = (sh[13:12] == 2'b01) && (sh[11:10] == 2'b10) && (sh[9:5] == PHY_ADDR);
         rep = phy_regs[sh[4:0]];
      end
      if (rc == PRE + 32) begin
         last_frame = sh;
         if (sh[31:30] == 2'b01 && sh[29:28] == 2'b01 && sh[27:23] == PHY_ADDR)
            phy_regs[sh[22:18]] = sh[15:0];
      end
   end

   always @(negedge mdc) begin
      if (hit && rc == PRE + 15) begin
         drv = 1'b1; dbit = 1'b0;
      end else if (hit && rc >= PRE + 16 && rc <= PRE + 31) begin
         drv = 1'b1; dbit = rep[15 - (rc - PRE - 16)];
      end else begin
         drv = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (mdc) hi_len++;
      else if (hi_len != 0) begin
         if (hi_len != exp_half) half_bad++;
         hi_len = 0;
      end
      if (mdio_o !== prev_o && prev_mdc && mdc) chg_bad++;
      prev_o = mdio_o;
      prev_mdc = mdc;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_cmd(input logic [4:0] a, input logic [4:0] r);
      return 32'h6002_0000 | (32'(a) << 23) | (32'(r) << 18);
   endfunction
   function automatic logic [31:0] wr_cmd(input logic [4:0] a, input logic [4:0] r, input logic [15:0] v);
      return 32'h5002_0000 | (32'(a) << 23) | (32'(r) << 18) | 32'(v);
   endfunction
   function automatic logic [15:0] pat(input int r);
      return 16'((r * 16'h0B3D) ^ 16'h5A00);
   endfunction

   task automatic put_cmd(input logic [31:0] w);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_we = 1'b0;
   endtask
   task automatic clr_evt(input logic [31:0] m);
      @(negedge clk); evt_we = 1'b1; evt_wdata = m;
      @(negedge clk); evt_we = 1'b0;
   endtask
   task automatic set_div(input int v);
      @(negedge clk); div_we = 1'b1; div_wdata = DIV_W'(v);
      @(negedge clk); div_we = 1'b0;
   endtask
   task automatic phy_arm(input logic [31:0] w);
      rc = 0; hit = 1'b0; cur_rd = (w[29:28] == 2'b10);
   endtask
   task automatic wait_evt();
      int t = 0;
      while (!evt_q[23] && t < 20000) begin @(negedge clk); t++; end
   endtask
   task automatic run_frame(input logic [31:0] w);
      phy_arm(w);
      put_cmd(w);
      wait_evt();
      clr_evt(32'h0080_0000);
   endtask

   task automatic finish_up();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 data", data_q, 32'h0);
      chk("R1 evt", evt_q, 32'h0);
      chk("R1 mdc", 32'(mdc), 32'h0);
      chk("R1 oe", 32'(mdio_oe), 32'h0);
      chk("R1 div", 32'(div_q), 32'd4);

      // Sweep all registers at the present PHY with the fastest divider
      set_div(1); exp_half = 1;
      for (int r = 0; r < 32; r++) begin
         logic [31:0] w;
         w = wr_cmd(PHY_ADDR, 5'(r), pat(r));
         run_frame(w);
         chk("R7 data after write", data_q, w);
         chk("R2 frame seen", last_frame, w);
         w = rd_cmd(PHY_ADDR, 5'(r));
         run_frame(w);
         chk("R6 read reply", data_q, {w[31:16], pat(r)});
         chk("R2 read header", {16'h0, last_frame[31:16]}, {16'h0, w[31:16]});
      end
      chk("R2 preamble ones", 32'(pre_bad), 0);
      chk("R2 write drive", 32'(drv_bad), 0);
      chk("R5 release on read", 32'(rel_bad), 0);
      chk("R4 change only on fall", 32'(chg_bad), 0);
      chk("R10 idle after frames", {30'h0, mdc, mdio_oe}, 32'h0);

      // Absent PHY addresses read all ones
      for (int a = 0; a < 32; a++) begin
         if (a != int'(PHY_ADDR)) begin
            logic [31:0] w;
            w = rd_cmd(5'(a), 5'(a));
            run_frame(w);
            chk("R6 absent phy", data_q, {w[31:16], 16'hFFFF});
         end
      end

      // Exact frame length and clock phase length for several dividers
      for (int n = 0; n < 6; n++) begin
         int h;
         h = (n == 0) ? 1 : n;
         set_div(n); exp_half = h; half_bad = 0;
         phy_arm(rd_cmd(PHY_ADDR, 5'd2));
         @(negedge clk); cmd_we = 1'b1; cmd_wdata = rd_cmd(PHY_ADDR, 5'd2);
         @(posedge clk); #1 cmd_we = 1'b0;
         repeat (128 * h - 1) @(posedge clk);
         #1 chk("R3 not yet done", 32'(evt_q[23]), 32'h0);
         @(posedge clk);
         #1 chk("R3 done on time", 32'(evt_q[23]), 32'h1);
         @(negedge clk);
         chk("R3 phase length", 32'(half_bad), 0);
         chk("R6 timed read", data_q, {rd_cmd(PHY_ADDR, 5'd2) >> 16, pat(2)});
         clr_evt(32'h0080_0000);
      end

      // Completion and clear in the same cycle: set wins
      set_div(1); exp_half = 1;
      phy_arm(rd_cmd(PHY_ADDR, 5'd9));
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = rd_cmd(PHY_ADDR, 5'd9);
      @(posedge clk); #1 cmd_we = 1'b0;
      repeat (127) @(posedge clk);
      #1 evt_we = 1'b1; evt_wdata = 32'h0080_0000;
      @(posedge clk); #1 evt_we = 1'b0;
      chk("R8 set wins over clear", 32'(evt_q[23]), 32'h1);
      clr_evt(32'h0);
      chk("R8 zero write keeps bit", 32'(evt_q[23]), 32'h1);
      clr_evt(32'h0080_0000);
      chk("R8 one write clears", 32'(evt_q[23]), 32'h0);

      // Overlapping command is dropped
      phy_arm(rd_cmd(PHY_ADDR, 5'd7));
      put_cmd(rd_cmd(PHY_ADDR, 5'd7));
      repeat (20) @(negedge clk);
      put_cmd(wr_cmd(PHY_ADDR, 5'd7, 16'h0000));
      chk("R9 overlap flagged", 32'(evt_q[22]), 32'h1);
      wait_evt();
      chk("R9 read unharmed", data_q, {rd_cmd(PHY_ADDR, 5'd7) >> 16, pat(7)});
      clr_evt(32'h0080_0000);
      chk("R9 overlap sticky", evt_q, 32'h0040_0000);
      clr_evt(32'h0040_0000);
      chk("R9 overlap cleared", evt_q, 32'h0);
      run_frame(rd_cmd(PHY_ADDR, 5'd7));
      chk("R9 phy reg untouched", data_q, {rd_cmd(PHY_ADDR, 5'd7) >> 16, pat(7)});
      chk("R10 idle line", {30'h0, mdc, mdio_oe}, 32'h0);

      finish_up();
   end
endmodule